// File: doc/BRIEF.md
# Prescaled UART Baud Rate Generator

This block produces the timing strobes that a UART transmitter and receiver run from. A free-running reference clock, usually from a crystal or an external oscillator, is first slowed by a prescaler. The prescaler divides either by one or by four, chosen by one control bit. A 16-bit programmable divisor then divides the result again. The output is a one-cycle enable at sixteen times the serial bit rate. A second one-cycle tick marks every sixteenth enable, which gives one strobe per bit period.

Software loads the divisor one byte at a time, and sets the prescale choice, through a small write port. Any write that reaches the divisor or the control register restarts both counters at once. The new rate therefore begins cleanly, with no short period. A receiver can use the resync input to align the bit tick to a detected start-bit edge. For a wanted bit rate, the divisor is the reference frequency divided by the prescale factor and then by sixteen times the bit rate.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset, and for as long as no write follows it, both `x16_en` and `bit_tick` stay low. Reset clears the divisor to 0 and selects prescale by 1.
- R2: With prescale by 1 and divisor D (D ≥ 1), `x16_en` is high for exactly one cycle in every D reference cycles. The period does not drift.
- R3: With the control register bit 7 set to 1, the prescale factor is 4 and the enable period is 4·D cycles. Bit 7 set to 0 selects a factor of 1.
- R4: The divisor D is {high byte, low byte}. The low byte is written at `wr_addr` = 0, the high byte at `wr_addr` = 1, and the control register at `wr_addr` = 2.
- R5: While D = 0, `x16_en` and `bit_tick` never pulse.
- R6: A write to address 0, 1 or 2 restarts the count. The first `x16_en` after the write comes in the P-th cycle after the write edge, where P = prescale·D, and no enable comes earlier.
- R7: A write to address 3 is ignored. It changes no register and does not restart the count.
- R8: `bit_tick` pulses together with every 16th `x16_en`.
- R9: `resync` clears the sixteen-count. `bit_tick` is low in any cycle where `resync` is high, and the next tick comes with the 16th enable after the resync cycle.
- R10: Control register bits 6 to 0 have no effect on the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 divisor low, 1 divisor high, 2 control |
| wr_data | input | 8 | Write data; bit 7 of a control write selects prescale by 4 |
| resync | input | 1 | Clears the sixteen-count of the bit tick |
| x16_en | output | 1 | One-cycle enable at sixteen times the bit rate |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth enable |

## Verification
The assertions assume that the divisor and the prescale choice change only through a write. They also assume that reset is held low for at least one clock edge before any pulse is judged. The stimulus changes no register except through the write port, and it starts with several cycles of reset. It drives `resync` as single-cycle pulses at irregular offsets, including offsets that can fall on an enable. It rewrites registers in the middle of a count period, so that the restart properties are exercised on a running counter rather than an idle one.

// File: rtl/uart_rate_pkg.sv
// Shared defaults for the baud rate generator.
// Assumes the divisor width is a whole number of bytes.
package uart_rate_pkg;
    localparam int BYTE_W     = 8;   // width of one write-port byte
    localparam int DIV_BYTES  = 2;   // bytes that make up the divisor
    localparam int ADDR_W     = 2;   // write address width
    localparam int CTRL_ADDR  = 2;   // address of the control register
    localparam int PSEL_BIT   = 7;   // control bit choosing the slow prescale
    localparam int PRESC_SLOW = 4;   // slow prescale factor
    localparam int OVS        = 16;  // oversampling ratio per bit
endpackage

// File: rtl/uart_rate_regs.sv
// Divisor bytes and the prescale select, loaded through a byte write port.
// Assumes byte i of the divisor sits at address i and the control register
// sits at CTRL_ADDR. Any accepted write raises reload for one cycle.
module uart_rate_regs #(
    parameter int BYTE_W    = uart_rate_pkg::BYTE_W,
    parameter int DIV_BYTES = uart_rate_pkg::DIV_BYTES,
    parameter int ADDR_W    = uart_rate_pkg::ADDR_W,
    parameter int CTRL_ADDR = uart_rate_pkg::CTRL_ADDR,
    localparam int DIV_W    = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_psel,
    output logic [DIV_W-1:0]  divisor,
    output logic              slow_sel,
    output logic              reload
);
    logic [DIV_BYTES-1:0] byte_hit;
    logic                 ctrl_hit;

    for (genvar gi = 0; gi < DIV_BYTES; gi++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        assign byte_hit[gi] = wr_en && (wr_addr == ADDR_W'(gi));
        // Hold one byte of the divisor.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (byte_hit[gi])
                byte_q <= wr_data;
        end
        assign divisor[gi*BYTE_W +: BYTE_W] = byte_q;
    end

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    // Hold the prescale select bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slow_sel <= 1'b0;
        else if (ctrl_hit)
            slow_sel <= wr_psel;
    end

    // Restart the counters on any accepted write.
    always_comb reload = ctrl_hit || (|byte_hit);

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reload) |=> ($stable(divisor) && $stable(slow_sel)));
endmodule

// File: rtl/uart_rate_prescaler.sv
// Divides the reference clock by 1 or by PRESC_SLOW and emits a one-cycle
// tick per prescaled period. Assumes slow_sel changes only together with reload.
module uart_rate_prescaler #(
    parameter int PRESC_SLOW = uart_rate_pkg::PRESC_SLOW,
    localparam int PCNT_W    = (PRESC_SLOW > 1) ? $clog2(PRESC_SLOW) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic slow_sel,
    output logic presc_tick
);
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] plimit;

    // Choose the terminal count for the selected factor.
    always_comb plimit = slow_sel ? PCNT_W'(PRESC_SLOW - 1) : '0;
    // Flag the last cycle of a prescaled period.
    always_comb presc_tick = (pcnt == plimit);

    // Count reference cycles inside one prescaled period.
    always_ff @(posedge clk) begin
        if (!rst_n || reload || presc_tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PCNT_W'(1);
    end

    // R3
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_tick && slow_sel && !reload) |=> !presc_tick);
endmodule

// File: rtl/uart_rate_divider.sv
// Counts prescaled ticks up to the programmed divisor and emits the
// sixteen-times enable. A divisor of zero holds the counter and gives no output.
// Assumes the divisor changes only together with reload.
module uart_rate_divider #(
    parameter int DIV_W = uart_rate_pkg::BYTE_W * uart_rate_pkg::DIV_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             presc_tick,
    input  logic [DIV_W-1:0] divisor,
    output logic             x16_en
);
    logic [DIV_W-1:0] dcnt;
    logic             active;
    logic             wrap;

    // Decode the enable and terminal conditions.
    always_comb begin
        active = (divisor != '0);
        wrap   = (dcnt == divisor - DIV_W'(1));
        x16_en = active && presc_tick && wrap;
    end

    // Count prescaled ticks within one divisor period.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)
            dcnt <= '0;
        else if (presc_tick && active)
            dcnt <= wrap ? '0 : dcnt + DIV_W'(1);
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x16_en && !reload && divisor != DIV_W'(1)) |=> !x16_en);
endmodule

// File: rtl/uart_rate_bitcnt.sv
// Counts sixteen-times enables and marks every OVS-th as a bit tick.
// resync clears the count and suppresses the tick in its own cycle.
module uart_rate_bitcnt #(
    parameter int OVS       = uart_rate_pkg::OVS,
    localparam int BCNT_W   = (OVS > 1) ? $clog2(OVS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x16_en,
    input  logic resync,
    output logic bit_tick
);
    logic [BCNT_W-1:0] bcnt;
    logic              last;

    // Flag the final enable of a bit period.
    always_comb begin
        last     = (bcnt == BCNT_W'(OVS - 1));
        bit_tick = x16_en && last && !resync;
    end

    // Track enables within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || resync)
            bcnt <= '0;
        else if (x16_en)
            bcnt <= last ? '0 : bcnt + BCNT_W'(1);
    end

    // R8
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
    // R9
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !bit_tick);
endmodule

// File: rtl/uart_rate_gen.sv
// Top of the baud rate generator: register port, prescaler, divisor
// counter and bit counter. Assumes a single reference clock domain.
module uart_rate_gen #(
    parameter int BYTE_W     = uart_rate_pkg::BYTE_W,
    parameter int DIV_BYTES  = uart_rate_pkg::DIV_BYTES,
    parameter int ADDR_W     = uart_rate_pkg::ADDR_W,
    parameter int CTRL_ADDR  = uart_rate_pkg::CTRL_ADDR,
    parameter int PSEL_BIT   = uart_rate_pkg::PSEL_BIT,
    parameter int PRESC_SLOW = uart_rate_pkg::PRESC_SLOW,
    parameter int OVS        = uart_rate_pkg::OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              resync,
    output logic              x16_en,
    output logic              bit_tick
);
    localparam int DIV_W = BYTE_W * DIV_BYTES;

    logic [DIV_W-1:0] divisor;
    logic             slow_sel;
    logic             reload;
    logic             presc_tick;

    uart_rate_regs #(
        .BYTE_W(BYTE_W), .DIV_BYTES(DIV_BYTES),
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_psel(wr_data[PSEL_BIT]),
        .divisor(divisor), .slow_sel(slow_sel), .reload(reload)
    );

    uart_rate_prescaler #(.PRESC_SLOW(PRESC_SLOW)) u_presc (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .slow_sel(slow_sel), .presc_tick(presc_tick)
    );

    uart_rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .reload(reload), .presc_tick(presc_tick),
        .divisor(divisor), .x16_en(x16_en)
    );

    uart_rate_bitcnt #(.OVS(OVS)) u_bits (
        .clk(clk), .rst_n(rst_n), .x16_en(x16_en),
        .resync(resync), .bit_tick(bit_tick)
    );

    // R6
    reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (!x16_en || (divisor == DIV_W'(1) && !slow_sel)));
endmodule

// File: tb/uart_rate_gen_bench.sv
`timescale 1ns/1ps
module uart_rate_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       resync = 1'b0;
    logic       x16_en;
    logic       bit_tick;

    uart_rate_gen u_uart_rate_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .resync(resync), .x16_en(x16_en), .bit_tick(bit_tick)
    );

    always #4 clk = ~clk;

    // Reference model state: divisor, slow flag, cycles since restart, enables in bit.
    int    m_div = 0, m_slow = 0, m_t = 0, m_b = 0;
    int    vectors = 0, miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    function automatic bit exp_x16();
        int p;
        p = (m_slow != 0 ? 4 : 1) * m_div;
        return (m_div != 0) && ((m_t % p) == p - 1);
    endfunction

    function automatic bit exp_tick();
        return exp_x16() && (m_b == 15) && !resync;
    endfunction

    // Compare in the cycle, then advance the model at the edge.
    task automatic tick();
        bit ex, et;
        @(negedge clk);
        #2;
        if (rst_n) begin
            ex = exp_x16();
            et = exp_tick();
            vectors++;
            if (x16_en !== ex || bit_tick !== et) begin
                miscompares++;
                $display("FAIL %s t=%0t x16_en=%b bit_tick=%b expected %b %b",
                         cur_req, $time, x16_en, bit_tick, ex, et);
            end
        end
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_div = 0; m_slow = 0; m_t = 0; m_b = 0;
        end else begin
            if (resync) m_b = 0;
            else if (exp_x16()) m_b = (m_b + 1) % 16;
            if (wr_en && wr_addr != 2'd3) begin
                case (wr_addr)
                    2'd0: m_div = (m_div & 32'hFF00) | int'(wr_data);
                    2'd1: m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
                    default: m_slow = int'(wr_data[7]);
                endcase
                m_t = 0;
            end else begin
                m_t++;
            end
        end
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
        finish_run();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        cur_req = "R1"; run(40);             // idle after reset, divisor 0
        cur_req = "R2"; wr(2'd0, 8'd3); run(60);
        cur_req = "R8"; wr(2'd0, 8'd1); run(50);
        cur_req = "R4"; wr(2'd1, 8'd1); wr(2'd0, 8'd2); run(600);  // D = 258
        cur_req = "R3"; wr(2'd2, 8'h80); wr(2'd0, 8'd5); wr(2'd1, 8'd0); run(400);
        cur_req = "R10"; wr(2'd2, 8'hFF); run(50); wr(2'd2, 8'h7F); run(50);
        cur_req = "R9";
        wr(2'd0, 8'd1);
        run(37); resync = 1'b1; tick(); resync = 1'b0; run(40);
        for (int i = 0; i < 12; i++) begin
            run(i + 3); resync = 1'b1; tick(); resync = 1'b0;
        end
        run(60);
        cur_req = "R7"; wr(2'd0, 8'd7); run(13); wr(2'd3, 8'h55); run(40);
        cur_req = "R6"; run(3); wr(2'd0, 8'd7); run(30); wr(2'd2, 8'h80); run(60);
        cur_req = "R5"; wr(2'd0, 8'd0); run(100);
        cur_req = "R3"; wr(2'd1, 8'h09); wr(2'd0, 8'h00); wr(2'd2, 8'h80); run(19000);
        cur_req = "R2"; wr(2'd2, 8'h00); wr(2'd1, 8'd0); wr(2'd0, 8'd1); run(40);
        cur_req = "R1"; rst_n = 1'b0; run(2); rst_n = 1'b1; run(50);
        finish_run();
    end
endmodule